// File: doc/BRIEF.md
# Command Stream Decoder with Staged Register File

This block sits behind a byte-wide link and turns a stream of framed commands into register updates and copy descriptors for a display pipeline. Each command opens with a fixed prefix byte and an opcode byte. The set-register command carries a register address and a value. The copy command carries a source address, a pixel count and a destination address, and the block reports it as a single-cycle descriptor for a downstream copy engine.

The register file has two copies: a shadow array and an active array. Downstream logic reads only the active array. A write of the lock value to the reserved control address freezes the active array. Later writes then land only in the shadow array. A write of the unlock value copies the whole shadow array into the active array in one cycle, so a new display mode takes effect all at once.

Bytes that arrive while the decoder is idle and are not the prefix are discarded and counted. An unrecognised opcode sends the decoder back to idle without counting it.

Top module: `cmd_stream_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the decoder returns to idle. After that edge `locked` reads 0, `copy_valid` reads 0, `drop_count` reads 0, and every address of the read port returns 0.
- R2: The sequence 0xAF, 0x20, A, V with A other than 0xFF, sent while unlocked, makes `rd_data` for address A equal V from the cycle after the byte V is accepted.
- R3: The sequence 0xAF, 0x20, 0xFF, 0x00 sets `locked` to 1. While locked, set-register writes leave every value seen at the read port unchanged.
- R4: The sequence 0xAF, 0x20, 0xFF, 0xFF clears `locked`. From the next cycle every write staged while locked is visible at the read port. A later write to the same address wins over an earlier one.
- R5: Writes to address 0xFF are never stored, so reading 0xFF keeps returning 0. A write to 0xFF with any value other than 0x00 or 0xFF leaves `locked` unchanged.
- R6: The sequence 0xAF, 0x6A, then seven bytes S2 S1 S0 N D2 D1 D0 raises `copy_valid` for exactly one cycle, in the cycle after D0 is accepted. In that cycle `copy_src` = {S2,S1,S0}, `copy_count` = N and `copy_dst` = {D2,D1,D0}.
- R7: A byte other than 0xAF accepted while idle is dropped. It adds 1 to `drop_count` and changes neither the registers nor `copy_valid`.
- R8: An opcode other than 0x20 or 0x6A returns the decoder to idle without changing `drop_count`, and the next byte is decoded as a new command start.
- R9: Inside a command, after the opcode, the byte 0xAF is ordinary payload: register address, value or copy field.
- R10: `drop_count` saturates at all ones and never decreases outside reset.
- R11: A byte is accepted only in a cycle with `in_valid` high (`in_ready` is always 1). Idle gaps between bytes do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Always 1; a byte is taken in every valid cycle |
| rd_addr | input | 8 | Read address into the active register array |
| rd_data | output | 8 | Active register value at `rd_addr` |
| locked | output | 1 | Register file lock state |
| copy_valid | output | 1 | One-cycle copy descriptor strobe |
| copy_src | output | 24 | Copy source address |
| copy_count | output | 8 | Copy pixel count |
| copy_dst | output | 24 | Copy destination address |
| drop_count | output | ERR_W | Saturating count of discarded idle bytes |

## Verification
The bench builds the decoder with ERR_W = 3, so the drop counter reaches its all-ones ceiling after seven stray bytes and saturation can be tested in a short run. All other parameters keep their framing defaults. This lets the bench exercise the real prefix, opcodes and lock codes: lock and unlock around staged writes, 0xAF bytes used as payload, and recovery after an unknown opcode.

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder #(
  parameter int         ERR_W      = 16,
  parameter logic [7:0] PREFIX     = 8'hAF,
  parameter logic [7:0] OP_SETREG  = 8'h20,
  parameter logic [7:0] OP_COPY    = 8'h6A,
  parameter logic [7:0] CTRL_ADDR  = 8'hFF,
  parameter logic [7:0] LOCK_VAL   = 8'h00,
  parameter logic [7:0] UNLOCK_VAL = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  input  logic [7:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic             locked,
  output logic             copy_valid,
  output logic [23:0]      copy_src,
  output logic [7:0]       copy_count,
  output logic [23:0]      copy_dst,
  output logic [ERR_W-1:0] drop_count
);
  localparam int NREG   = 256;
  localparam int CBYTES = 7;
  localparam int PW     = 8 * CBYTES;
  localparam int CW     = $clog2(CBYTES + 1);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADDR, S_VAL, S_COPY} st_t;

  st_t             state;
  logic [7:0]      addr_q;
  logic [CW-1:0]   cnt;
  logic [PW-1:0]   payload;
  logic            lock_q;
  logic            pulse_q;
  logic [ERR_W-1:0] drop_q;
  logic [7:0]      active [NREG];
  logic [7:0]      shadow [NREG];

  assign in_ready   = 1'b1;
  assign rd_data    = active[rd_addr];
  assign locked     = lock_q;
  assign copy_valid = pulse_q;
  assign copy_src   = payload[PW-1 -: 24];
  assign copy_count = payload[31:24];
  assign copy_dst   = payload[23:0];
  assign drop_count = drop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      cnt     <= '0;
      payload <= '0;
      lock_q  <= 1'b0;
      pulse_q <= 1'b0;
      drop_q  <= '0;
      for (int i = 0; i < NREG; i++) begin
        active[i] <= '0;
        shadow[i] <= '0;
      end
    end else begin
      pulse_q <= 1'b0;
      if (in_valid) begin
        case (state)
          S_IDLE: begin
            if (in_data == PREFIX) state <= S_OPC;
            else if (drop_q != {ERR_W{1'b1}}) drop_q <= drop_q + 1'b1;
          end
          S_OPC: begin
            if (in_data == OP_SETREG) state <= S_ADDR;
            else if (in_data == OP_COPY) begin
              state <= S_COPY;
              cnt   <= '0;
            end else state <= S_IDLE;
          end
          S_ADDR: begin
            addr_q <= in_data;
            state  <= S_VAL;
          end
          S_VAL: begin
            state <= S_IDLE;
            if (addr_q == CTRL_ADDR) begin
              if (in_data == LOCK_VAL) lock_q <= 1'b1;
              else if (in_data == UNLOCK_VAL) begin
                lock_q <= 1'b0;
                for (int i = 0; i < NREG; i++) active[i] <= shadow[i];
              end
            end else begin
              shadow[addr_q] <= in_data;
              if (!lock_q) active[addr_q] <= in_data;
            end
          end
          S_COPY: begin
            payload <= {payload[PW-9:0], in_data};
            cnt     <= cnt + 1'b1;
            if (cnt == CW'(CBYTES - 1)) begin
              state   <= S_IDLE;
              pulse_q <= 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmd_stream_decoder_chk.sv
module cmd_stream_decoder_chk #(
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [7:0]       in_data,
  input logic             locked,
  input logic             copy_valid,
  input logic [ERR_W-1:0] drop_count
);
  assert_copy_single_R6: assert property (@(posedge clk) disable iff (rst)
    copy_valid |=> !copy_valid);

  assert_copy_after_byte_R6: assert property (@(posedge clk) disable iff (rst)
    copy_valid |-> $past(in_valid));

  assert_lock_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(in_valid && in_data == 8'h00));

  assert_unlock_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(in_valid && in_data == 8'hFF));

  assert_drop_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(drop_count));

  assert_drop_monotonic_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> drop_count >= $past(drop_count));
endmodule

bind cmd_stream_decoder cmd_stream_decoder_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .locked(locked), .copy_valid(copy_valid), .drop_count(drop_count)
);

// File: tb/test_cmd_stream_decoder.sv
module test_cmd_stream_decoder;
  localparam int ERR_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [7:0]       in_data = '0;
  logic             in_ready;
  logic [7:0]       rd_addr = '0;
  logic [7:0]       rd_data;
  logic             locked;
  logic             copy_valid;
  logic [23:0]      copy_src;
  logic [7:0]       copy_count;
  logic [23:0]      copy_dst;
  logic [ERR_W-1:0] drop_count;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [55:0] exp_q[$];

  always #5 clk = ~clk;

  cmd_stream_decoder #(.ERR_W(ERR_W)) i_cmd_stream_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .locked(locked), .copy_valid(copy_valid), .copy_src(copy_src),
    .copy_count(copy_count), .copy_dst(copy_dst), .drop_count(drop_count)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic set_reg(logic [7:0] a, logic [7:0] v);
    send(8'hAF); send(8'h20); send(a); send(v);
  endtask

  task automatic send_copy(logic [23:0] s, logic [7:0] n, logic [23:0] d);
    exp_q.push_back({s, n, d});
    send(8'hAF); send(8'h6A);
    send(s[23:16]); send(s[15:8]); send(s[7:0]);
    send(n);
    send(d[23:16]); send(d[15:8]); send(d[7:0]);
  endtask

  task automatic read_chk(string tag, logic [7:0] a, logic [7:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1 check(tag, {24'h0, rd_data}, {24'h0, exp});
  endtask

  task automatic out_chk(string tag, logic [31:0] act_unused, logic [31:0] exp);
    @(negedge clk);
    check(tag, act_unused, exp);
  endtask

  // Monitor: pops expected descriptors as strobes appear
  always @(negedge clk) begin
    if (!rst && copy_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 unexpected copy actual=%0h expected=none", {copy_src, copy_count, copy_dst});
      end else begin
        logic [55:0] e;
        e = exp_q.pop_front();
        check("R6 copy_src",   {8'h0, copy_src},    {8'h0, e[55:32]});
        check("R6 copy_count", {24'h0, copy_count}, {24'h0, e[31:24]});
        check("R6 copy_dst",   {8'h0, copy_dst},    {8'h0, e[23:0]});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    #1 rst = 1'b0;
    // R1 reset state
    @(negedge clk);
    check("R1 locked", {31'h0, locked}, 0);
    check("R1 copy_valid", {31'h0, copy_valid}, 0);
    check("R1 drop_count", {29'h0, drop_count}, 0);
    check("R11 in_ready", {31'h0, in_ready}, 1);
    read_chk("R1 reg00", 8'h00, 8'h00);
    read_chk("R1 reg10", 8'h10, 8'h00);
    read_chk("R1 regFF", 8'hFF, 8'h00);

    // R2 plain write, R9 prefix value as payload
    set_reg(8'h10, 8'h5A);
    read_chk("R2 reg10", 8'h10, 8'h5A);
    set_reg(8'h11, 8'hAF);
    read_chk("R9 value AF", 8'h11, 8'hAF);
    set_reg(8'hAF, 8'h33);
    read_chk("R9 addr AF", 8'hAF, 8'h33);

    // R11 gaps between bytes
    send(8'hAF); idle(3); send(8'h20); idle(2); send(8'h20); idle(4); send(8'h77);
    read_chk("R11 gapped write", 8'h20, 8'h77);
    check("R11 no drops", {29'h0, drop_count}, 0);

    // R3 lock and staging
    set_reg(8'hFF, 8'h00);
    out_chk("R3 locked", {31'h0, locked}, 1);
    set_reg(8'h10, 8'hA5);
    set_reg(8'h30, 8'hC3);
    set_reg(8'h30, 8'h3C);
    read_chk("R3 reg10 held", 8'h10, 8'h5A);
    read_chk("R3 reg30 held", 8'h30, 8'h00);
    // R5 other value to control address
    set_reg(8'hFF, 8'h55);
    out_chk("R5 lock kept", {31'h0, locked}, 1);
    // copy still works while locked
    send_copy(24'h123456, 8'h08, 24'hABCDEF);
    // R4 unlock commits
    set_reg(8'hFF, 8'hFF);
    out_chk("R4 unlocked", {31'h0, locked}, 0);
    read_chk("R4 reg10", 8'h10, 8'hA5);
    read_chk("R4 reg30 last wins", 8'h30, 8'h3C);
    read_chk("R4 reg20 kept", 8'h20, 8'h77);
    read_chk("R5 regFF", 8'hFF, 8'h00);

    // R6 / R9 copy with prefix bytes inside
    send_copy(24'hAF00AF, 8'hAF, 24'h0000AF);
    send(8'hAF); send(8'h6A);
    exp_q.push_back({24'hFFFFFF, 8'hFF, 24'h010203});
    send(8'hFF); idle(2); send(8'hFF); send(8'hFF); send(8'hFF);
    send(8'h01); send(8'h02); idle(1); send(8'h03);

    // R7 stray bytes
    send(8'h01); send(8'h20);
    out_chk("R7 drop 2", {29'h0, drop_count}, 2);
    read_chk("R7 reg10 intact", 8'h10, 8'hA5);

    // R8 unknown opcode then resync
    send(8'hAF); send(8'h99);
    out_chk("R8 no count", {29'h0, drop_count}, 2);
    set_reg(8'h40, 8'h11);
    read_chk("R8 resync write", 8'h40, 8'h11);
    send(8'hAF); send(8'hAF);
    set_reg(8'h41, 8'h22);
    read_chk("R8 after AF opcode", 8'h41, 8'h22);
    out_chk("R8 count still 2", {29'h0, drop_count}, 2);

    // R10 saturation
    for (int i = 0; i < 10; i++) send(8'h00);
    out_chk("R10 saturated", {29'h0, drop_count}, 7);
    read_chk("R10 reg00 intact", 8'h00, 8'h00);

    idle(3);
    check("R6 all copies seen", exp_q.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule